// File: doc/BRIEF.md
# Circular Trace Byte Buffer

This block stores recent debug trace history. A producer hands it trace entries one byte per cycle. Each entry starts with a message byte. A message that reports an indirect branch is followed on the input by four address bytes. The block places every entry into a 256-byte circular store. It lays out an indirect entry with the four address bytes first and the message byte last, so the newest byte in the store is always a message byte. A reader that walks backwards from the end of the store can therefore parse it.

Two capture modes are selectable. In wrap-around mode the oldest bytes are overwritten without end. In fill-once mode the block takes entries only while the whole entry still fits, and it then raises a sticky full flag. Two checkpoint registers hold the start positions of the two most recent entries that were tagged as checkpoints. When capture is switched off, software drains the store one byte per read strobe through a 32-bit data word. The drain starts with the oldest byte.

Top module: `trace_buf`

## Requirements
- R1: While rst_ni is low, full_o, chkpt0_o and chkpt1_o are zero and the write index is 0. The store contents are not cleared.
- R2: An accepted message byte (in_addr_i=0) with in_ind_i=0 occupies one byte at the write index. With in_ind_i=1 the message byte goes to write index+4. The next four address bytes (in_addr_i=1) fill write index+0..+3 in arrival order. The write index then advances by the entry length (1 or 5), modulo 256.
- R3: In wrap-around mode (wrap_i=1), after capture is switched off, 256 reads return the bytes from oldest to newest, starting at the write index. The last byte returned is the newest message byte.
- R4: In fill-once mode (wrap_i=0), an entry is accepted only if its full length fits in the bytes still free. Otherwise the entry and its address bytes are dropped and full_o rises. full_o also rises when exactly 256 bytes are stored. While it is set, every entry is dropped, and it stays set until reset.
- R5: In fill-once mode, the drain starts at store index 0.
- R6: Each accepted entry with in_chk_i=1 on its message byte moves chkpt0_o into chkpt1_o. It then loads chkpt0_o with the index of the entry's first byte. Dropped entries leave both registers unchanged.
- R7: rd_data_o[7:0] is the store byte at the read pointer, and rd_data_o[31:8] is always zero.
- R8: Each cycle with rd_en_i=1 and cap_en_i=0 advances the read pointer by one, modulo 256. While cap_en_i=1, rd_en_i has no effect and the pointer follows the drain start of the current mode.
- R9: While cap_en_i=0, input bytes are ignored: the store, the checkpoints and full_o do not change.
- R10: An address byte that arrives with no address slot pending is ignored. A new message byte abandons any address slots still pending from the previous entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_en_i | input | 1 | Capture enable |
| wrap_i | input | 1 | 1 = wrap-around, 0 = fill-once |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_addr_i | input | 1 | 1 = address byte, 0 = message byte |
| in_ind_i | input | 1 | Message is followed by four address bytes |
| in_chk_i | input | 1 | Message entry sets a checkpoint |
| rd_en_i | input | 1 | Read strobe, advances the read pointer |
| rd_data_o | output | 32 | Zero-extended byte at the read pointer |
| full_o | output | 1 | Fill-once store is full |
| chkpt0_o | output | 8 | Start index of the newest checkpoint entry |
| chkpt1_o | output | 8 | Start index of the older checkpoint entry |

## Verification
The case most likely to go wrong is a checkpoint-setting indirect entry that exactly fills the fill-once store. On one clock edge that entry must shift the checkpoint registers and raise the full flag. The bench builds this case by sending 251 single-byte messages and then a five-byte checkpoint entry. A behavioural model compares both checkpoints and the flag on every clock. A second run stops three bytes short of full, so the indirect entry must be turned away: full_o must rise, and the checkpoints must stay where they were.

// File: rtl/trace_buf_pkg.sv
package trace_buf_pkg;
  localparam int unsigned TB_DEPTH      = 256;
  localparam int unsigned TB_DW         = 8;
  localparam int unsigned TB_RW         = 32;
  localparam int unsigned TB_ADDR_BYTES = 4;
endpackage

// File: rtl/trace_buf_mem.sv
module trace_buf_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // contents are deliberately left out of reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/trace_buf_wr.sv
module trace_buf_wr #(
  parameter int unsigned DEPTH      = 256,
  parameter int unsigned DW         = 8,
  parameter int unsigned ADDR_BYTES = 4,
  localparam int unsigned AW        = $clog2(DEPTH),
  localparam int unsigned CW        = $clog2(DEPTH + 1),
  localparam int unsigned PW        = $clog2(ADDR_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_en_i,
  input  logic          wrap_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_addr_i,
  input  logic          in_ind_i,
  input  logic          in_chk_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [AW-1:0] wptr_nxt_o,
  output logic          chk_set_o,
  output logic [AW-1:0] chk_idx_o,
  output logic          full_o
);
  logic [AW-1:0] wptr_q, wptr_d, acur_q, acur_d;
  logic [CW-1:0] cnt_q, cnt_d, len;
  logic [PW-1:0] pend_q, pend_d;
  logic          full_q, full_d, drop_q, drop_d;
  logic          msg_in, adr_in, fits;
  logic [CW:0]   room_sum;

  always_comb begin
    msg_in   = cap_en_i & in_valid_i & ~in_addr_i;
    adr_in   = cap_en_i & in_valid_i & in_addr_i & (pend_q != '0);
    len      = in_ind_i ? CW'(ADDR_BYTES + 1) : CW'(1);
    room_sum = {1'b0, cnt_q} + {1'b0, len};
    fits     = wrap_i | (~full_q & (room_sum <= (CW+1)'(DEPTH)));

    wptr_d  = wptr_q;
    acur_d  = acur_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    full_d  = full_q;
    drop_d  = drop_q;
    we_o    = 1'b0;
    waddr_o = wptr_q;
    wdata_o = in_data_i;

    if (msg_in) begin
      // a new message always closes any open address slots
      pend_d = in_ind_i ? PW'(ADDR_BYTES) : '0;
      acur_d = wptr_q;
      drop_d = ~fits;
      if (fits) begin
        we_o    = 1'b1;
        waddr_o = wptr_q + (in_ind_i ? AW'(ADDR_BYTES) : '0);
        wptr_d  = wptr_q + AW'(len);
        if (!wrap_i) begin
          cnt_d = cnt_q + len;
          if (cnt_d == CW'(DEPTH)) full_d = 1'b1;
        end
      end else begin
        full_d = 1'b1;
      end
    end else if (adr_in) begin
      pend_d = pend_q - 1'b1;
      acur_d = acur_q + 1'b1;
      if (!drop_q) begin
        we_o    = 1'b1;
        waddr_o = acur_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      acur_q <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
      full_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      acur_q <= acur_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      full_q <= full_d;
      drop_q <= drop_d;
    end
  end

  assign wptr_nxt_o = wptr_d;
  assign chk_set_o  = msg_in & fits & in_chk_i;
  assign chk_idx_o  = wptr_q;
  assign full_o     = full_q;
endmodule

// File: rtl/trace_buf_ckpt.sv
module trace_buf_ckpt #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] ck0_o,
  output logic [AW-1:0] ck1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck0_o <= '0;
      ck1_o <= '0;
    end else if (set_i) begin
      ck1_o <= ck0_o;
      ck0_o <= idx_i;
    end
  end
endmodule

// File: rtl/trace_buf_rd.sv
module trace_buf_rd #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_en_i,
  input  logic          wrap_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] wptr_nxt_i,
  output logic [AW-1:0] rptr_o
);
  // while capturing, keep the pointer parked on the drain start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rptr_o <= '0;
    else if (cap_en_i) rptr_o <= wrap_i ? wptr_nxt_i : '0;
    else if (rd_en_i)  rptr_o <= rptr_o + 1'b1;
  end
endmodule

// File: rtl/trace_buf.sv
module trace_buf
  import trace_buf_pkg::*;
#(
  parameter int unsigned DEPTH      = TB_DEPTH,
  parameter int unsigned DW         = TB_DW,
  parameter int unsigned RW         = TB_RW,
  parameter int unsigned ADDR_BYTES = TB_ADDR_BYTES,
  localparam int unsigned AW        = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_en_i,
  input  logic          wrap_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_addr_i,
  input  logic          in_ind_i,
  input  logic          in_chk_i,
  input  logic          rd_en_i,
  output logic [RW-1:0] rd_data_o,
  output logic          full_o,
  output logic [AW-1:0] chkpt0_o,
  output logic [AW-1:0] chkpt1_o
);
  logic          we;
  logic [AW-1:0] waddr, wptr_nxt, chk_idx, rptr;
  logic [DW-1:0] wdata, rbyte;
  logic          chk_set;

  trace_buf_wr #(.DEPTH(DEPTH), .DW(DW), .ADDR_BYTES(ADDR_BYTES)) i_wr (
    .clk_i, .rst_ni, .cap_en_i, .wrap_i, .in_valid_i, .in_data_i,
    .in_addr_i, .in_ind_i, .in_chk_i,
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .wptr_nxt_o(wptr_nxt),
    .chk_set_o(chk_set), .chk_idx_o(chk_idx), .full_o(full_o)
  );

  trace_buf_mem #(.DEPTH(DEPTH), .DW(DW)) i_mem (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(rptr), .rdata_o(rbyte)
  );

  trace_buf_ckpt #(.AW(AW)) i_ckpt (
    .clk_i, .rst_ni, .set_i(chk_set), .idx_i(chk_idx),
    .ck0_o(chkpt0_o), .ck1_o(chkpt1_o)
  );

  trace_buf_rd #(.AW(AW)) i_rd (
    .clk_i, .rst_ni, .cap_en_i, .wrap_i, .rd_en_i,
    .wptr_nxt_i(wptr_nxt), .rptr_o(rptr)
  );

  assign rd_data_o = RW'(rbyte);
endmodule

// File: rtl/trace_buf_sva.sv
module trace_buf_sva #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned RW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cap_en_i,
  input logic          wrap_i,
  input logic          rd_en_i,
  input logic [RW-1:0] rd_data_o,
  input logic          full_o,
  input logic [AW-1:0] chkpt0_o,
  input logic [AW-1:0] chkpt1_o,
  input logic [AW-1:0] rptr_i
);
  a_r7_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o >> DW) == '0);

  a_r4_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> full_o);

  a_r4_full_freezes_ckpt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !wrap_i) |=> ($stable(chkpt0_o) && $stable(chkpt1_o)));

  a_r6_ckpt_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chkpt0_o != $past(chkpt0_o)) |-> (chkpt1_o == $past(chkpt0_o)));

  a_r9_idle_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> ($stable(full_o) && $stable(chkpt0_o) && $stable(chkpt1_o)));

  a_r8_read_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i && rd_en_i) |=> (rptr_i == AW'($past(rptr_i) + 1'b1)));

  a_r5_fill_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && !wrap_i) |=> (rptr_i == '0));
endmodule

bind trace_buf trace_buf_sva #(.AW(AW), .DW(DW), .RW(RW)) i_sva (
  .clk_i, .rst_ni, .cap_en_i, .wrap_i, .rd_en_i, .rd_data_o, .full_o,
  .chkpt0_o, .chkpt1_o, .rptr_i(rptr)
);

// File: tb/test_trace_buf.sv
module test_trace_buf;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cap_en = 1'b0, wrap = 1'b1, in_valid = 1'b0, in_addr = 1'b0;
  logic        in_ind = 1'b0, in_chk = 1'b0, rd_en = 1'b0;
  logic [7:0]  in_data = '0;
  logic [31:0] rd_data;
  logic        full;
  logic [7:0]  ck0, ck1;

  trace_buf i_trace_buf (
    .clk_i(clk), .rst_ni(rst_n), .cap_en_i(cap_en), .wrap_i(wrap),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_addr_i(in_addr),
    .in_ind_i(in_ind), .in_chk_i(in_chk), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .full_o(full), .chkpt0_o(ck0), .chkpt1_o(ck1)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  int mm[256];
  int wp = 0, rp = 0, cnt = 0, c0 = 0, c1 = 0;
  bit mfull = 0;
  int slots[$];

  initial foreach (mm[i]) mm[i] = -1;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp = 0; rp = 0; cnt = 0; c0 = 0; c1 = 0; mfull = 0;
      slots.delete();
    end else begin
      if (cap_en && in_valid && !in_addr) begin
        int len;
        len = in_ind ? 5 : 1;
        slots.delete();
        if (wrap || (!mfull && cnt + len <= 256)) begin
          mm[(wp + len - 1) % 256] = in_data;
          for (int k = 0; k < len - 1; k++) slots.push_back((wp + k) % 256);
          if (in_chk) begin c1 = c0; c0 = wp; end
          wp = (wp + len) % 256;
          if (!wrap) begin
            cnt += len;
            if (cnt == 256) mfull = 1;
          end
        end else begin
          mfull = 1;
          if (in_ind) for (int k = 0; k < 4; k++) slots.push_back(-1);
        end
      end else if (cap_en && in_valid && in_addr && slots.size() > 0) begin
        int s;
        s = slots.pop_front();
        if (s >= 0) mm[s] = in_data;
      end
      if (cap_en) rp = wrap ? wp : 0;
      else if (rd_en) rp = (rp + 1) % 256;
    end
  end

  // per-clock comparison of the flag and checkpoint outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(full == mfull, "R4", "full_o", full, mfull);
      check(ck0 == 8'(c0) && ck1 == 8'(c1), "R6", "chkpt0/1",
            {ck0, ck1}, {8'(c0), 8'(c1)});
    end
  end

  task automatic do_reset(bit mode);
    rst_n = 1'b0; cap_en = 0; wrap = mode; in_valid = 0; rd_en = 0;
    repeat (2) @(negedge clk);
    check(full == 0 && ck0 == 0 && ck1 == 0, "R1", "reset state",
          {full, ck0, ck1}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, bit a, bit ind, bit ck);
    in_valid = 1; in_data = d; in_addr = a; in_ind = ind; in_chk = ck;
    @(negedge clk);
    in_valid = 0; in_addr = 0; in_ind = 0; in_chk = 0;
  endtask

  task automatic entry(int e, bit ind, bit ck);
    send(8'(8'h80 | (e & 8'h7f)), 0, ind, ck);
    if (ind) for (int k = 0; k < 4; k++) send(8'((e * 4 + k) & 8'h7f), 1, 0, 0);
  endtask

  logic [7:0] last_byte;

  task automatic drain(string tag);
    for (int i = 0; i < 256; i++) begin
      if (mm[rp] >= 0)
        check(rd_data === 32'(mm[rp]), (i == 0) ? {"R8 ", tag} : tag,
              "rd_data_o", rd_data, mm[rp]);
      check(rd_data[31:8] == 0, "R7", "upper bits", rd_data[31:8], 0);
      last_byte = rd_data[7:0];
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
    end
  endtask

  initial begin
    // wrap-around with stray/abandoned address bytes and reads during capture
    do_reset(1'b1);
    cap_en = 1; rd_en = 1;
    for (int e = 0; e < 120; e++) begin
      if (e == 50) send(8'h11, 1, 0, 0);            // R10 stray address byte
      if (e == 70) begin                             // R10 abandoned slots
        send(8'hC6, 0, 1, 0);
        send(8'h21, 1, 0, 0);
        send(8'h22, 1, 0, 0);
      end
      entry(e, e % 3 == 0, e % 5 == 0);
    end
    rd_en = 0; cap_en = 0;
    @(negedge clk);
    begin
      logic [7:0] h0;
      h0 = ck0;
      for (int k = 0; k < 6; k++) send(8'hF0, 0, 1, 1);
      check(ck0 == h0, "R9", "chkpt0 after idle input", ck0, h0);
    end
    drain("R2 R3 R10");
    check(last_byte[7] == 1'b1, "R3", "newest drained byte is message",
          last_byte, 8'h80 | last_byte);

    // fill-once: a checkpoint entry exactly fills the store
    do_reset(1'b0);
    cap_en = 1;
    for (int e = 0; e < 251; e++) entry(e, 0, e == 100);
    entry(251, 1, 1);
    check(full == 1 && ck0 == 8'd251 && ck1 == 8'd100, "R4",
          "full with checkpoint same edge", {full, ck0, ck1}, {1'b1, 8'd251, 8'd100});
    entry(252, 0, 1);
    cap_en = 0;
    @(negedge clk);
    drain("R5");

    // fill-once: an indirect entry that does not fit is rejected
    do_reset(1'b0);
    cap_en = 1;
    for (int e = 0; e < 253; e++) entry(e, 0, e == 10 || e == 20);
    check(full == 0, "R4", "not yet full", full, 0);
    entry(253, 1, 1);
    check(full == 1 && ck0 == 8'd20, "R4", "rejected entry", {full, ck0}, {1'b1, 8'd20});
    entry(254, 0, 1);
    cap_en = 0;
    @(negedge clk);
    drain("R4 R5");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule